// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block is the shift and rotate execution unit of a 16-bit processor datapath. It accepts an operand of byte or word size, an incoming set of status flags, an operation code and a shift count. It then moves the operand one bit position per clock until the count runs out. When it finishes, it returns the result together with fresh carry, parity, zero, sign and overflow flags.

Seven operations are supported: logical shift left, logical shift right, arithmetic shift right, plain rotate in either direction, and rotate through carry in either direction. The count is either the constant 1 or a value taken from an 8-bit count register. Only the low five bits of that value are used, so a run never takes more than 33 cycles. The carry always ends up holding the last bit that left the operand.

A single-cycle `start_i` hands a job to the unit while it is idle. `busy_o` stays high for the whole iteration. A one-cycle `done_o` pulse then marks the cycle in which `result_o` and `flags_o` are valid. Both outputs hold their values until the next job completes.

Top module: `shift_rot_unit`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o`, `result_o` and `flags_o` are all zero.
- R2: `start_i` while idle raises `busy_o` at the next edge. `busy_o` stays high for exactly m+1 cycles, where m is the effective count, and `done_o` is high for the single cycle after `busy_o` falls. A `start_i` while busy is ignored and changes neither the timing nor the result.
- R3: When `count_one_i`=1 the effective count is 1 and `count_i` is ignored. Otherwise the effective count is `count_i[4:0]`, and bits 7:5 of `count_i` have no effect.
- R4: When the effective count is 0, `result_o` equals the operand (masked to its size) and `flags_o` equals `flags_i`.
- R5: Op code 0 is the logical left shift. It inserts zeros at bit 0, and the carry takes the last bit that left the MSB.
- R6: Op code 1 is the logical right shift. It inserts zeros at the MSB, and the carry takes the last bit that left bit 0.
- R7: Op code 2 is the arithmetic right shift. It keeps the original sign bit in the MSB on every step, and the carry takes the last bit that left bit 0.
- R8: Op codes 3 and 4 rotate left and right. Each bit that leaves one end enters the other end and is also copied into the carry.
- R9: Op codes 5 and 6 rotate left and right through the carry. The leaving bit goes to the carry, and the previous carry enters the opposite end.
- R10: `word_i`=1 selects a 16-bit operand with MSB at bit 15. `word_i`=0 selects the low byte with MSB at bit 7; operand bits 15:8 are ignored and `result_o[15:8]` is 0.
- R11: For a nonzero count, the flag vector bit order is 0 carry, 1 parity, 2 zero, 3 sign, 4 overflow. Parity is 1 when `result_o[7:0]` holds an even number of ones. Zero is 1 when the sized result is zero. Sign is the sized result MSB.
- R12: For a nonzero count, overflow is set as follows, judged at the last step:
  - for op codes 0, 3 and 5, it is the result MSB XOR the final carry;
  - for op code 1, it is the MSB as it stood before the last step;
  - for op code 2, it is 0;
  - for op codes 4 and 6, it is the XOR of the two top bits of the sized result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job request, accepted when idle |
| op_i | input | 3 | Operation code, 0 to 6 |
| word_i | input | 1 | 1 selects word size, 0 selects byte size |
| operand_i | input | 16 | Operand value |
| flags_i | input | 5 | Incoming flags: carry, parity, zero, sign, overflow (bit 0 upward) |
| count_one_i | input | 1 | 1 selects a count of one |
| count_i | input | 8 | Count register value |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Shifted or rotated result |
| flags_o | output | 5 | Updated flags, same bit order as `flags_i` |

## Verification
The assertions take for granted that `op_i` carries one of the seven defined codes whenever `start_i` is accepted. The operation, size and count are sampled only at acceptance, so the checker's own copy of them is valid only if no other input path alters the job. The stimulus drives only codes 0 to 6, changes inputs only away from the clock edge, and returns `start_i` to 0 one cycle after each request. The single deliberate exception is one pulse issued while the unit is busy, which exercises the ignore rule.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_NOP = 3'd7
  } shr_op_e;

  localparam int FLAG_W = 5;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_ZF  = 2;
  localparam int FL_SF  = 3;
  localparam int FL_OF  = 4;
endpackage

// File: rtl/shr_step.sv
module shr_step
  import shr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              word_i,
  input  logic              cf_i,
  input  shr_op_e           op_i,
  output logic [DATA_W-1:0] data_o,
  output logic              cf_o,
  output logic              msb_o
);
  logic fill;

  always_comb begin
    msb_o  = word_i ? data_i[DATA_W-1] : data_i[BYTE_W-1];
    fill   = 1'b0;
    data_o = data_i;
    cf_o   = cf_i;
    unique case (op_i)
      OP_SHL, OP_ROL, OP_RCL: begin
        if (op_i == OP_ROL)      fill = msb_o;
        else if (op_i == OP_RCL) fill = cf_i;
        data_o = {data_i[DATA_W-2:0], fill};
        cf_o   = msb_o;
      end
      OP_SHR, OP_SAR, OP_ROR, OP_RCR: begin
        if (op_i == OP_SAR)      fill = msb_o;
        else if (op_i == OP_ROR) fill = data_i[0];
        else if (op_i == OP_RCR) fill = cf_i;
        data_o = data_i >> 1;
        if (word_i) data_o[DATA_W-1] = fill;
        else        data_o[BYTE_W-1] = fill;
        cf_o   = data_i[0];
      end
      default: ;
    endcase
    // byte mode keeps the upper lane cleared
    if (!word_i) data_o[DATA_W-1:BYTE_W] = '0;
  end
endmodule

// File: rtl/shr_flags.sv
module shr_flags
  import shr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              word_i,
  input  logic              cf_i,
  input  logic              prev_msb_i,
  input  logic              zero_cnt_i,
  input  shr_op_e           op_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic msb, msb2, ovf;

  always_comb begin
    msb  = word_i ? res_i[DATA_W-1] : res_i[BYTE_W-1];
    msb2 = word_i ? res_i[DATA_W-2] : res_i[BYTE_W-2];
    unique case (op_i)
      OP_SHL, OP_ROL, OP_RCL: ovf = msb ^ cf_i;
      OP_SHR:                 ovf = prev_msb_i;
      OP_SAR:                 ovf = 1'b0;
      OP_ROR, OP_RCR:         ovf = msb ^ msb2;
      default:                ovf = flags_i[FL_OF];
    endcase
    flags_o[FL_CF] = cf_i;
    flags_o[FL_PF] = ~^res_i[7:0];
    flags_o[FL_ZF] = word_i ? (res_i == '0) : (res_i[BYTE_W-1:0] == '0);
    flags_o[FL_SF] = msb;
    flags_o[FL_OF] = ovf;
    if (zero_cnt_i) flags_o = flags_i;
  end
endmodule

// File: rtl/shr_count.sv
module shr_count #(
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             one_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             init_zero_o
);
  logic [MASK_W-1:0] cnt_q, init_cnt;

  assign init_cnt    = one_i ? MASK_W'(1) : count_i[MASK_W-1:0];
  assign init_zero_o = (init_cnt == '0);
  assign zero_o      = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= init_cnt;
    else if (dec_i && !zero_o)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              count_one_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic              busy_q, done_q, cf_q, pre_msb_q, word_q, zc_q;
  logic [DATA_W-1:0] data_q, res_q;
  logic [FLAG_W-1:0] flin_q, flags_q, flags_calc;
  shr_op_e           op_q;
  logic [DATA_W-1:0] step_data;
  logic              step_cf, step_msb, cnt_zero, init_zero, accept;

  assign accept = start_i && !busy_q;

  shr_count #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .one_i       (count_one_i),
    .count_i     (count_i),
    .dec_i       (busy_q),
    .zero_o      (cnt_zero),
    .init_zero_o (init_zero)
  );

  shr_step #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_step (
    .data_i (data_q),
    .word_i (word_q),
    .cf_i   (cf_q),
    .op_i   (op_q),
    .data_o (step_data),
    .cf_o   (step_cf),
    .msb_o  (step_msb)
  );

  shr_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_flags (
    .res_i      (data_q),
    .word_i     (word_q),
    .cf_i       (cf_q),
    .prev_msb_i (pre_msb_q),
    .zero_cnt_i (zc_q),
    .op_i       (op_q),
    .flags_i    (flin_q),
    .flags_o    (flags_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cf_q      <= 1'b0;
      pre_msb_q <= 1'b0;
      word_q    <= 1'b0;
      zc_q      <= 1'b0;
      op_q      <= OP_NOP;
      data_q    <= '0;
      res_q     <= '0;
      flin_q    <= '0;
      flags_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        data_q    <= word_i ? operand_i : {{(DATA_W-BYTE_W){1'b0}}, operand_i[BYTE_W-1:0]};
        cf_q      <= flags_i[FL_CF];
        pre_msb_q <= 1'b0;
        word_q    <= word_i;
        zc_q      <= init_zero;
        op_q      <= shr_op_e'(op_i);
        flin_q    <= flags_i;
      end else if (busy_q) begin
        if (!cnt_zero) begin
          data_q    <= step_data;
          cf_q      <= step_cf;
          pre_msb_q <= step_msb;
        end else begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          res_q   <= data_q;
          flags_q <= flags_calc;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
  assign flags_o  = flags_q;
endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        op_i,
  input logic              word_i,
  input logic              count_one_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o,
  input logic [4:0]        flags_o
);
  logic       word_c, zc_c;
  logic [2:0] op_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_c <= 1'b0;
      zc_c   <= 1'b1;
      op_c   <= 3'd0;
    end else if (start_i && !busy_o) begin
      word_c <= word_i;
      zc_c   <= !count_one_i && (count_i[MASK_W-1:0] == '0);
      op_c   <= op_i;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R10
  byte_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !word_c) |-> (result_o[DATA_W-1:BYTE_W] == '0));
  // R11
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zc_c) |-> (flags_o[2] == (word_c ? (result_o == '0)
                                                  : (result_o[BYTE_W-1:0] == '0))));
  // R11
  parity_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zc_c) |-> (flags_o[1] == ~^result_o[7:0]));
  // R12
  sar_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zc_c && op_c == 3'd2) |-> !flags_o[4]);
endmodule

bind shift_rot_unit shift_rot_unit_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .MASK_W(MASK_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .op_i        (op_i),
  .word_i      (word_i),
  .count_one_i (count_one_i),
  .count_i     (count_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .result_o    (result_o),
  .flags_o     (flags_o)
);

// File: tb/shift_rot_unit_test.sv
module shift_rot_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic        word_i = 1'b0;
  logic [15:0] operand_i = '0;
  logic [4:0]  flags_i = '0;
  logic        count_one_i = 1'b0;
  logic [7:0]  count_i = '0;
  logic        busy_o, done_o;
  logic [15:0] result_o;
  logic [4:0]  flags_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  shift_rot_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .word_i(word_i), .operand_i(operand_i), .flags_i(flags_i),
    .count_one_i(count_one_i), .count_i(count_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .flags_o(flags_o)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog R2 actual=%0d cycles expected=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [20:0] act,
                       input logic [20:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns {flags, result}
  function automatic logic [20:0] model(input int op, input bit wd, input logic [15:0] opnd,
                                        input logic [4:0] fl, input bit one, input logic [7:0] cnt);
    int m = one ? 1 : int'(cnt[4:0]);
    int mi = wd ? 15 : 7;
    logic [15:0] mask = wd ? 16'hFFFF : 16'h00FF;
    logic [15:0] d = opnd & mask;
    logic c = fl[0];
    logic pm = 1'b0;
    logic ov;
    logic [4:0] f;
    if (m == 0) return {fl, d};
    for (int i = 0; i < m; i++) begin
      logic top = d[mi];
      logic bot = d[0];
      pm = top;
      if (op == 0 || op == 3 || op == 5) begin
        logic fill = (op == 0) ? 1'b0 : (op == 3) ? top : c;
        d = ((d << 1) | 16'(fill)) & mask;
        c = top;
      end else begin
        logic fill = (op == 1) ? 1'b0 : (op == 2) ? top : (op == 4) ? bot : c;
        d = (d >> 1) | (16'(fill) << mi);
        c = bot;
      end
    end
    case (op)
      0, 3, 5: ov = d[mi] ^ c;
      1:       ov = pm;
      2:       ov = 1'b0;
      default: ov = d[mi] ^ d[mi-1];
    endcase
    f = {ov, d[mi], (d == 16'h0), ~^d[7:0], c};
    return {f, d};
  endfunction

  function automatic string op_req(input int op);
    case (op)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3, 4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input int op, input bit wd, input logic [15:0] opnd, input logic [4:0] fl,
                     input bit one, input logic [7:0] cnt, input bit poke);
    logic [20:0] exp = model(op, wd, opnd, fl, one, cnt);
    int m = one ? 1 : int'(cnt[4:0]);
    int bc = 0;
    string tag;
    @(negedge clk_i);
    op_i = 3'(op); word_i = wd; operand_i = opnd; flags_i = fl;
    count_one_i = one; count_i = cnt; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o && bc < 40) begin
      bc++;
      if (poke && bc == 1) begin
        start_i = 1'b1; operand_i = ~opnd; op_i = 3'((op + 1) % 7);
      end else start_i = 1'b0;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check(bc == m + 1 && done_o, poke ? "R2 start-while-busy" : "R2 R3 latency",
          21'(bc), 21'(m + 1));
    if (m == 0) tag = "R4";
    else tag = wd ? op_req(op) : {op_req(op), " R10"};
    check({flags_o[0], result_o} == {exp[16], exp[15:0]}, tag,
          {4'h0, flags_o[0], result_o}, {4'h0, exp[16], exp[15:0]});
    if (m != 0) begin
      check(flags_o[3:1] == exp[19:17], "R11 flags", 21'(flags_o), 21'(exp[20:16]));
      check(flags_o[4] == exp[20], "R12 overflow", 21'(flags_o), 21'(exp[20:16]));
    end else begin
      check(flags_o == exp[20:16], "R4 flags", 21'(flags_o), 21'(exp[20:16]));
    end
    @(negedge clk_i);
    check(!done_o, "R2 done pulse", 21'(done_o), 21'(0));
  endtask

  initial begin
    logic [15:0] pats [3];
    int n = 0;
    pats[0] = 16'h8001; pats[1] = 16'hB5C3; pats[2] = 16'h0100;
    repeat (3) @(negedge clk_i);
    // R1
    check(!busy_o && !done_o && result_o == 0 && flags_o == 0, "R1 reset",
          {busy_o, done_o, 3'b0, result_o}, 21'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int op = 0; op < 7; op++)
      for (int wd = 0; wd < 2; wd++)
        for (int c = 0; c < 32; c++)
          for (int p = 0; p < 3; p++)
            for (int ci = 0; ci < 2; ci++) begin
              logic [4:0] fl = 5'((n * 7) & 5'h1E) | 5'(ci);
              // upper count bits vary to exercise the R3 masking
              run(op, wd[0], pats[p], fl, 1'b0, {3'(n), 5'(c)}, 1'b0);
              n++;
            end
    // R3: count-of-one selection overrides count_i
    for (int op = 0; op < 7; op++) begin
      run(op, 1'b1, 16'hC3A5, 5'b00001, 1'b1, 8'd9, 1'b0);
      run(op, 1'b0, 16'hFF96, 5'b10100, 1'b1, 8'd0, 1'b0);
    end
    // R2: start while busy is ignored
    run(2, 1'b1, 16'h9234, 5'b00000, 1'b0, 8'd6, 1'b1);
    run(6, 1'b0, 16'h005A, 5'b00001, 1'b0, 8'd11, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule